// File: doc/BRIEF.md
# Multi-Channel DMA Register Bank

This block holds the software-visible registers of a multi-channel DMA controller. A host reaches it through a plain 32-bit read/write port with a byte address. Five controller-wide registers sit in the low address range: a control word, two interrupt masks and two interrupt sources. Above a base offset, each channel owns a fixed window of eight 32-bit registers: a control/status word, a size word, a source pointer with its wrap mask, a destination pointer with its wrap mask, a link pointer and a scratch pointer.

The transfer engine stays outside the block. It raises sticky status events into each channel's control/status word through a pulse input. It receives one-cycle start and cancel pulses that the bank derives from software writes to the channel enable bit. Reading a channel control/status word hands software the flags and clears them in the same access, so no flag is lost or reported twice. Accesses to addresses that decode to nothing return zero, change nothing, and raise a one-cycle flag.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register reads zero, except the source wrap mask (channel offset 0x0C) and destination wrap mask (channel offset 0x14) of every channel, which read 0xFFFFFFFC.
- R2: Word addresses below 0x20 select global registers: 0x00 control, 0x04 mask A, 0x08 mask B, 0x0C source A, 0x10 source B. At or above 0x20, channel = (addr-0x20)/0x20 and the register is ((addr-0x20) mod 0x20)/4, in the order control/status, size, source pointer, source mask, destination pointer, destination mask, link, scratch.
- R3: A read of a channel control/status word (offset 0x00) returns its value before the read and clears flag bits 19:16 on the following edge; a status event arriving in the same cycle is kept.
- R4: A write to a channel control/status word changes only bits 12:0; all other bits keep their value.
- R5: A write that sets enable bit 0 of a channel control/status word while it was clear gives a one-cycle start pulse for that channel in the cycle after the write; a write with bit 0 set while it was already set gives none.
- R6: A write to a channel control/status word with bit 0 clear gives a one-cycle cancel pulse for that channel in the cycle after the write.
- R7: Writes to the global control word (bit 0 is the pause request) are ignored and it always reads zero.
- R8: Both interrupt mask and both interrupt source registers take and return full 32-bit values.
- R9: An access to global offsets 0x14 to 0x1C, or to a channel number at or above the channel count, reads zero, changes no register, and raises the illegal flag for one cycle in the cycle after the access.
- R10: The seven channel registers other than the control/status word take and return full 32-bit values.
- R11: Bit k of a channel's 4-bit status event input sets bit 16+k of that channel's control/status word (16 error, 17 error interrupt, 18 done interrupt, 19 chunk interrupt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW (8) | Byte address, low two bits ignored |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data, valid in the cycle of rd_en |
| illegal_o | output | 1 | Pulse after an access to an undefined address |
| sts_set | input | NUM_CH*4 (16) | Status event pulses, four per channel |
| start_o | output | NUM_CH (4) | Per-channel start pulse |
| cancel_o | output | NUM_CH (4) | Per-channel cancel pulse |

## Verification
Directed sequences sweep every reset value, every channel register with distinct data, enable on-then-on-then-off writes, and status events with and without a coinciding read, which separates read-before-clear and set-wins ordering from a plain clear. Illegal global slots and the first window past the last channel are hit with reads and writes followed by readback, telling decode gaps apart from aliasing. A long random mix of reads, writes and status events over the whole map, including undefined addresses, then runs against a behavioural model compared every cycle, exposing wrong masking, lost flags or pulses on the wrong channel.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
   localparam logic [31:0] CSR_WMASK  = 32'h0000_1FFF;
   localparam int unsigned FLAG_LSB   = 16;
   localparam int unsigned FLAG_W     = 4;
   localparam int unsigned EN_BIT     = 0;
   localparam logic [31:0] WRAP_RESET = 32'hFFFF_FFFC;
   localparam int unsigned REGS_PER_CH = 8;
   localparam int unsigned GLOB_REGS  = 5;

   typedef enum logic [2:0] {
      CR_CTL  = 3'd0, CR_SIZE = 3'd1, CR_SRC  = 3'd2, CR_SRCW = 3'd3,
      CR_DST  = 3'd4, CR_DSTW = 3'd5, CR_LINK = 3'd6, CR_SCR  = 3'd7
   } ch_reg_e;

   typedef enum logic [2:0] {
      GR_CTL = 3'd0, GR_MSKA = 3'd1, GR_MSKB = 3'd2, GR_SRCA = 3'd3, GR_SRCB = 3'd4
   } glob_reg_e;
endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode #(
   parameter int unsigned AW      = 8,
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned CH_BASE = 32,
   parameter int unsigned WIN     = 32,
   localparam int unsigned CW     = $clog2(NUM_CH)
) (
   input  logic [AW-1:0] addr,
   output logic          glob_ok,
   output logic [2:0]    g_idx,
   output logic          ch_ok,
   output logic [CW-1:0] ch_idx,
   output logic [2:0]    r_idx
);
   localparam int unsigned WSH = $clog2(WIN);
   localparam logic [AW-1:0] BASE_A = AW'(CH_BASE);

   if (WIN < 32 || (WIN & (WIN - 1)) != 0) begin : g_bad_win
      $error("channel window must be a power of two of at least 32 bytes");
   end
   if (AW < 6) begin : g_bad_aw
      $error("address too narrow");
   end

   logic          is_glob;
   logic [AW-1:0] gword;
   logic [AW-1:0] off;
   logic [AW-1:0] win_no;
   logic          in_win;

   assign is_glob = addr < BASE_A;
   assign gword   = addr >> 2;
   assign glob_ok = is_glob && (gword < AW'(dma_regbank_pkg::GLOB_REGS));
   assign g_idx   = gword[2:0];

   assign off     = addr - BASE_A;
   assign win_no  = off >> WSH;
   assign in_win  = (off & AW'(WIN - 1)) < AW'(32);
   assign ch_ok   = !is_glob && (win_no < AW'(NUM_CH)) && in_win;
   assign ch_idx  = win_no[CW-1:0];
   assign r_idx   = off[4:2];
endmodule

// File: rtl/dma_rb_global.sv
module dma_rb_global #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          wr,
   input  logic [2:0]    g_idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   import dma_regbank_pkg::*;

   logic [DW-1:0] msk_a, msk_b, src_a, src_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msk_a <= '0;
         msk_b <= '0;
         src_a <= '0;
         src_b <= '0;
      end else if (sel && wr) begin
         case (g_idx)
            GR_MSKA: msk_a <= wdata;
            GR_MSKB: msk_b <= wdata;
            GR_SRCA: src_a <= wdata;
            GR_SRCB: src_b <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (g_idx)
         GR_MSKA: rdata = msk_a;
         GR_MSKB: rdata = msk_b;
         GR_SRCA: rdata = src_a;
         GR_SRCB: rdata = src_b;
         default: rdata = '0;
      endcase
   end

   AST_GLOB_CTL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (g_idx == GR_CTL) |-> (rdata == '0)); // R7
endmodule

// File: rtl/dma_rb_channel.sv
module dma_rb_channel #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          wr,
   input  logic          rd,
   input  logic [2:0]    r_idx,
   input  logic [DW-1:0] wdata,
   input  logic [3:0]    sts_set,
   output logic [DW-1:0] rdata,
   output logic          start,
   output logic          cancel
);
   import dma_regbank_pkg::*;

   if (DW != 32) begin : g_bad_dw
      $error("channel registers are 32 bits wide");
   end

   logic [DW-1:0] rf [REGS_PER_CH];
   logic          wr_ctl, rd_ctl;
   logic [DW-1:0] ctl_nxt;

   assign wr_ctl = sel && wr && (r_idx == CR_CTL);
   assign rd_ctl = sel && rd && (r_idx == CR_CTL);

   always_comb begin
      ctl_nxt = rf[0];
      if (rd_ctl) ctl_nxt[FLAG_LSB +: FLAG_W] = '0;
      if (wr_ctl) ctl_nxt = (ctl_nxt & ~CSR_WMASK) | (wdata & CSR_WMASK);
      ctl_nxt[FLAG_LSB +: FLAG_W] = ctl_nxt[FLAG_LSB +: FLAG_W] | sts_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start  <= 1'b0;
         cancel <= 1'b0;
         rf[0]  <= '0;
      end else begin
         start  <= wr_ctl && wdata[EN_BIT] && !rf[0][EN_BIT];
         cancel <= wr_ctl && !wdata[EN_BIT];
         rf[0]  <= ctl_nxt;
      end
   end

   for (genvar i = 1; i < REGS_PER_CH; i++) begin : g_reg
      localparam logic [DW-1:0] RST =
         (i == CR_SRCW || i == CR_DSTW) ? WRAP_RESET : '0;
      always_ff @(posedge clk) begin
         if (!rst_n)                              rf[i] <= RST;
         else if (sel && wr && r_idx == 3'(i))    rf[i] <= wdata;
      end
   end

   assign rdata = rf[r_idx];

   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctl && sts_set == '0) |=> (rf[0][FLAG_LSB +: FLAG_W] == '0)); // R3
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|sts_set) |=> ((rf[0][FLAG_LSB +: FLAG_W] & $past(sts_set)) == $past(sts_set))); // R11
   AST_WMASK_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> ((rf[0] & CSR_WMASK) == ($past(wdata) & CSR_WMASK))); // R4
   AST_WMASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !rd_ctl && sts_set == '0) |=> ((rf[0] & ~CSR_WMASK) == $past(rf[0] & ~CSR_WMASK))); // R4
   AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && wdata[EN_BIT] && !rf[0][EN_BIT]) |=> start); // R5
   AST_CANCEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |-> !rf[0][EN_BIT]); // R6
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank #(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned AW      = 8,
   parameter int unsigned DW      = 32,
   parameter int unsigned CH_BASE = 32,
   parameter int unsigned WIN     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [AW-1:0]         addr,
   input  logic [DW-1:0]         wdata,
   output logic [DW-1:0]         rdata,
   output logic                  illegal_o,
   input  logic [NUM_CH*4-1:0]   sts_set,
   output logic [NUM_CH-1:0]     start_o,
   output logic [NUM_CH-1:0]     cancel_o
);
   localparam int unsigned CW = $clog2(NUM_CH);

   if (NUM_CH < 2) begin : g_bad_nch
      $error("at least two channels required");
   end
   if (CH_BASE + NUM_CH * WIN > (1 << AW)) begin : g_bad_map
      $error("channel windows do not fit the address width");
   end

   logic          glob_ok, ch_ok, hit;
   logic [2:0]    g_idx, r_idx;
   logic [CW-1:0] ch_idx;
   logic [DW-1:0] g_rd;
   logic [DW-1:0] ch_rd [NUM_CH];

   dma_rb_decode #(.AW(AW), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .WIN(WIN)) u_dec (
      .addr(addr), .glob_ok(glob_ok), .g_idx(g_idx),
      .ch_ok(ch_ok), .ch_idx(ch_idx), .r_idx(r_idx)
   );

   dma_rb_global #(.DW(DW)) u_glob (
      .clk(clk), .rst_n(rst_n), .sel(glob_ok), .wr(wr_en),
      .g_idx(g_idx), .wdata(wdata), .rdata(g_rd)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma_rb_channel #(.DW(DW)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .sel(ch_ok && ch_idx == CW'(c)),
         .wr(wr_en), .rd(rd_en), .r_idx(r_idx), .wdata(wdata),
         .sts_set(sts_set[c*4 +: 4]),
         .rdata(ch_rd[c]), .start(start_o[c]), .cancel(cancel_o[c])
      );
   end

   assign hit = glob_ok || ch_ok;

   always_comb begin
      rdata = '0;
      if (rd_en && glob_ok)    rdata = g_rd;
      else if (rd_en && ch_ok) rdata = ch_rd[ch_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) illegal_o <= 1'b0;
      else        illegal_o <= (wr_en || rd_en) && !hit;
   end

   AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_o)); // R5
   AST_ONE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cancel_o)); // R6
   AST_ILL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !hit) |-> (rdata == '0)); // R9
   AST_ILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || rd_en) && !hit) |=> illegal_o); // R9
endmodule

// File: tb/dma_regbank_test.sv
`timescale 1ns/1ps
module dma_regbank_test;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        illegal_o;
   logic [15:0] sts_set = '0;
   logic [3:0]  start_o, cancel_o;

   always #2.5 clk = ~clk;

   dma_regbank uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .illegal_o(illegal_o), .sts_set(sts_set),
      .start_o(start_o), .cancel_o(cancel_o)
   );

   int errs = 0, checks = 0;
   bit finished = 0;

   logic [31:0] mch [NCH][8];
   logic [31:0] mg  [5];
   logic [3:0]  x_start = '0, x_cancel = '0;
   logic        x_ill = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [7:0] a);
      int ai = int'(a);
      if (ai < 32) return ((ai / 4) >= 1 && (ai / 4) <= 4) ? mg[ai / 4] : 32'h0;
      if ((ai - 32) / 32 >= NCH) return 32'h0;
      return mch[(ai - 32) / 32][((ai - 32) % 32) / 4];
   endfunction

   function automatic bit m_hit(input logic [7:0] a);
      int ai = int'(a);
      if (ai < 32) return (ai / 4) <= 4;
      return ((ai - 32) / 32) < NCH;
   endfunction

   task automatic m_reset();
      for (int c = 0; c < NCH; c++)
         for (int k = 0; k < 8; k++)
            mch[c][k] = (k == 3 || k == 5) ? 32'hFFFF_FFFC : 32'h0;
      for (int k = 0; k < 5; k++) mg[k] = 32'h0;
   endtask

   // One bus cycle: compare last cycle's pulses, drive, compare read data, update model.
   task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                      input logic [31:0] d, input logic [15:0] s, input string tag);
      int ai, c, k;
      logic old_en;
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
         chk("R5 start pulse", 32'(start_o[i]), 32'(x_start[i]));
         chk("R6 cancel pulse", 32'(cancel_o[i]), 32'(x_cancel[i]));
      end
      chk("R9 illegal flag", 32'(illegal_o), 32'(x_ill));
      wr_en = w; rd_en = r; addr = a; wdata = d; sts_set = s;
      #1;
      if (r) chk(tag, rdata, m_read(a));
      x_start = '0; x_cancel = '0;
      x_ill = (w || r) && !m_hit(a);
      ai = int'(a);
      if (ai >= 32 && m_hit(a)) begin
         c = (ai - 32) / 32; k = ((ai - 32) % 32) / 4;
         if (r && k == 0) mch[c][0][19:16] = 4'h0;
         if (w) begin
            if (k == 0) begin
               old_en = mch[c][0][0];
               mch[c][0] = (mch[c][0] & ~32'h1FFF) | (d & 32'h1FFF);
               x_start[c] = d[0] && !old_en;
               x_cancel[c] = !d[0];
            end else mch[c][k] = d;
         end
      end else if (ai < 32 && w && (ai / 4) >= 1 && (ai / 4) <= 4) begin
         mg[ai / 4] = d;
      end
      for (int i = 0; i < NCH; i++) mch[i][0][19:16] = mch[i][0][19:16] | s[i*4 +: 4];
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      cyc(1'b0, 1'b1, a, 32'h0, 16'h0, tag);
   endtask
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b1, 1'b0, a, d, 16'h0, "write");
   endtask

   initial begin
      #200000;
      if (!finished) begin
         errs++; checks++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      m_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values of all registers
      for (int c = 0; c < NCH; c++)
         for (int k = 0; k < 8; k++) rd(8'(32 + c*32 + k*4), "R1 reset value");
      for (int k = 0; k < 5; k++) rd(8'(k*4), "R1 global reset value");
      // R10 / R2: distinct data in every channel register
      for (int c = 0; c < NCH; c++)
         for (int k = 1; k < 8; k++) wr(8'(32 + c*32 + k*4), 32'hA500_0000 | 32'(c*256 + k));
      for (int c = 0; c < NCH; c++)
         for (int k = 1; k < 8; k++) rd(8'(32 + c*32 + k*4), "R10 R2 channel readback");
      // R4 / R5: write all ones to channel 1 control
      wr(8'h40, 32'hFFFF_FFFF);
      rd(8'h40, "R4 write mask");
      wr(8'h40, 32'h0000_0001);     // already enabled: no start (R5)
      wr(8'h40, 32'h0000_0000);     // cancel (R6)
      rd(8'h40, "R6 enable cleared");
      // R11 / R3: status events then read-clear
      cyc(1'b0, 1'b0, 8'h0, 32'h0, 16'h0F00, "R11 set");
      rd(8'h60, "R3 R11 flags before clear");
      rd(8'h60, "R3 flags cleared");
      cyc(1'b0, 1'b1, 8'h60, 32'h0, 16'h0500, "R3 read with coincident event");
      rd(8'h60, "R3 event kept over clear");
      rd(8'h60, "R3 cleared again");
      cyc(1'b0, 1'b0, 8'h0, 32'h0, 16'h0008, "R11 set ch0");
      wr(8'h20, 32'hFFFF_E000);     // R4: flags untouched by write
      rd(8'h20, "R4 flags keep through write");
      // R7 / R8 global
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, "R7 global control ignored");
      wr(8'h04, 32'h1234_5678); wr(8'h08, 32'h9ABC_DEF0);
      wr(8'h0C, 32'h0F0F_F0F0); wr(8'h10, 32'hFFFF_0001);
      for (int k = 1; k < 5; k++) rd(8'(k*4), "R8 mask/source readback");
      // R9 undefined addresses
      wr(8'h14, 32'hDEAD_BEEF); wr(8'h1C, 32'hDEAD_BEEF); wr(8'hA0, 32'hDEAD_BEEF);
      rd(8'h18, "R9 illegal read zero");
      rd(8'hA8, "R9 illegal channel read zero");
      rd(8'hFC, "R9 top address read zero");
      for (int k = 1; k < 5; k++) rd(8'(k*4), "R9 globals unchanged");
      rd(8'h20, "R9 channel 0 unchanged");
      // Random mix against the model
      for (int n = 0; n < 1500; n++) begin
         automatic logic [31:0] rnd = $urandom;
         automatic logic [7:0]  a = 8'((rnd % 44) * 4);
         automatic bit          w = rnd[8];
         automatic logic [15:0] s = (rnd[12:10] == 3'b000) ? 16'($urandom) : 16'h0;
         cyc(w, !w, a, $urandom, s, "R2 R3 R4 R10 random readback");
      end
      cyc(1'b0, 1'b0, 8'h0, 32'h0, 16'h0, "idle");
      cyc(1'b0, 1'b0, 8'h0, 32'h0, 16'h0, "idle");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule